// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend and Power-Down Control

This block sits in the command and burst front end of a synchronous DRAM device. It registers the external clock-enable pin on every rising clock edge and derives an internal enable from it. The internal enable decides whether the command decoder, the burst column sequencer and the write-data capture act on the current edge. A low level sampled at one edge therefore freezes the edge after it. A freeze during a running read or write burst is clock suspend. The burst column, the driven read word and the write path all hold, and commands and data that arrive at frozen edges are dropped.

When no burst is running, the same low level on the pin puts the device into power-down. In power-down a gate flag turns off the input buffers until the pin is sampled high again. The first enabled edge after power-down exit only tolerates a no-operation or deselect command. Any other command there is discarded and sets a sticky error flag. Bursts of 1, 2, 4 or 8 beats step the column sequentially and wrap inside the aligned block of that size. Each beat either captures one write word with its column or loads one read word from the array onto the output.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: `int_en` during the cycle after rising edge k equals the `cke` level sampled at edge k.
- R2: A read burst frozen by a low `cke` raises `out_hold` for as long as `int_en` is low. `out_hold` is low while `int_en` is high.
- R3: At an edge where `int_en` is low, `cmd`, `start_col` and `wdata` have no effect: no write strobe follows and no new burst starts.
- R4: `dq_out` keeps its value across every edge at which `int_en` is low.
- R5: The burst column (`cur_col` when no command is accepted) does not advance at an edge where `int_en` is low.
- R6: After `cke` is sampled high at edge m, the burst continues at edge m+1 from the column where it stopped.
- R7: With no burst running, `cke` sampled low sets `buf_gate` after that edge. `buf_gate` stays high while `cke` stays low.
- R8: `cke` sampled high during power-down clears `buf_gate` and raises `int_en` after that edge.
- R9: `bl_sel` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. The column increments by one and wraps inside the aligned block of that burst size. Command codes: NOP=0, DESEL=1, READ=2, WRITE=3.
- R10: Each enabled beat of a write burst, including the WRITE edge itself, pulses `wr_stb` for one cycle, with that beat's column on `wr_col` and the `wdata` present at that edge on `wr_data`.
- R11: On the first enabled edge after power-down exit, any command other than NOP (0) or DESEL (1) is discarded and sets `pd_err`, which stays high until reset.
- R12: Reset clears the burst, suspend, power-down and error state and drives `int_en` high, whatever level `cke` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | External clock-enable pin level |
| cmd | input | 3 | Decoded command (NOP=0, DESEL=1, READ=2, WRITE=3, others ignored) |
| bl_sel | input | 2 | Burst length select, latched at burst start |
| start_col | input | COL_W | Starting column of a READ or WRITE |
| wdata | input | DW | Write data word for the current edge |
| rd_data | input | DW | Array word for the column on `cur_col` |
| int_en | output | 1 | Internal clock enable |
| cur_col | output | COL_W | Column of the beat taken at the coming edge |
| wr_stb | output | 1 | Write beat strobe |
| wr_col | output | COL_W | Column of the captured write beat |
| wr_data | output | DW | Captured write word |
| dq_out | output | DW | Read word driven toward the pins |
| out_hold | output | 1 | Read burst frozen, output held |
| buf_gate | output | 1 | Input buffers gated off (power-down) |
| pd_err | output | 1 | Illegal command on first edge after power-down exit |

## Verification
The hardest situation to reach from the ports is a read burst frozen partway through while a conflicting READ with a different column sits on the inputs. This is the only point where the held column, the held output word and the dropped command can all be seen together. The stimulus starts an eight-beat read and lets one more beat through with `cke` already low. It then presents a new READ while the edge is frozen and checks `cur_col`, `dq_out` and `out_hold` before the release. The other hard case, an illegal command on the first edge after power-down exit, is reached by idling the burst, holding `cke` low and releasing it one edge before a WRITE.

// File: rtl/cke_pkg.sv
package cke_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_DESEL = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_ACT   = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_REF   = 3'd6,
        CMD_MRS   = 3'd7
    } cmd_e;

    typedef struct packed {
        logic busy;
        logic is_wr;
    } burst_flags_t;

    localparam int BEAT_W = 4;

    function automatic logic [BEAT_W-1:0] bl_beats(input logic [1:0] sel);
        return BEAT_W'(1) << sel;
    endfunction

    function automatic logic is_quiet_cmd(input logic [2:0] c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

    function automatic logic is_col_cmd(input logic [2:0] c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/cke_gate.sv
module cke_gate
    import cke_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       busy_nxt,
    output logic       int_en,
    output logic       accept,
    output logic       pd,
    output logic       first_edge,
    output logic       pd_err
);
    logic cke_q, pd_q, first_q, err_q;
    logic illegal;

    assign int_en     = cke_q;
    assign accept     = cke_q && !first_q;
    assign illegal    = cke_q && first_q && !is_quiet_cmd(cmd);
    assign pd         = pd_q;
    assign first_edge = first_q;
    assign pd_err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q   <= 1'b1;
            pd_q    <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            cke_q <= cke;
            if (pd_q)
                pd_q <= !cke;
            else
                pd_q <= !cke && !busy_nxt;
            if (pd_q && cke)
                first_q <= 1'b1;
            else if (cke_q)
                first_q <= 1'b0;
            err_q <= err_q | illegal;
        end
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import cke_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_en,
    input  logic             accept,
    input  logic [2:0]       cmd,
    input  logic [1:0]       bl_sel,
    input  logic [COL_W-1:0] start_col,
    output burst_flags_t     flags,
    output logic             busy_nxt,
    output logic [COL_W-1:0] col_q,
    output logic             beat,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_col
);
    logic [BEAT_W-1:0] left_q, left_after, beats;
    logic [COL_W-1:0]  mask_q, mask_now, step_col;
    burst_flags_t      flags_q;
    logic              start;

    assign start    = accept && is_col_cmd(cmd);
    assign beats    = bl_beats(bl_sel);
    assign mask_now = start ? COL_W'(beats - BEAT_W'(1)) : mask_q;
    assign beat     = start || (int_en && flags_q.busy);
    assign beat_wr  = beat && (start ? (cmd == CMD_WRITE) : flags_q.is_wr);
    assign beat_col = start ? start_col : col_q;
    assign step_col = (beat_col & ~mask_now) | ((beat_col + COL_W'(1)) & mask_now);
    assign left_after = start ? beats - BEAT_W'(1) : left_q - BEAT_W'(1);
    assign busy_nxt = beat ? (left_after != '0) : flags_q.busy;
    assign flags    = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            left_q  <= '0;
            col_q   <= '0;
            mask_q  <= '0;
        end else if (beat) begin
            flags_q.busy  <= busy_nxt;
            flags_q.is_wr <= start ? (cmd == CMD_WRITE) : flags_q.is_wr;
            left_q        <= left_after;
            col_q         <= step_col;
            mask_q        <= mask_now;
        end
    end
endmodule

// File: rtl/beat_io.sv
module beat_io #(
    parameter int COL_W = 9,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             beat_wr,
    input  logic [COL_W-1:0] beat_col,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rd_data,
    output logic             wr_stb,
    output logic [COL_W-1:0] wr_col,
    output logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    dq_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_col  <= '0;
            wr_data <= '0;
            dq_out  <= '0;
        end else begin
            wr_stb <= beat && beat_wr;
            if (beat && beat_wr) begin
                wr_col  <= beat_col;
                wr_data <= wdata;
            end
            if (beat && !beat_wr)
                dq_out <= rd_data;
        end
    end
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
    import cke_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic [2:0]       cmd,
    input  logic [1:0]       bl_sel,
    input  logic [COL_W-1:0] start_col,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rd_data,
    output logic             int_en,
    output logic [COL_W-1:0] cur_col,
    output logic             wr_stb,
    output logic [COL_W-1:0] wr_col,
    output logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    dq_out,
    output logic             out_hold,
    output logic             buf_gate,
    output logic             pd_err
);
    logic             accept_w, busy_nxt_w, first_w, beat_w, beat_wr_w;
    logic [COL_W-1:0] col_w;
    burst_flags_t     flags_w;

    cke_gate u_gate (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .busy_nxt(busy_nxt_w),
        .int_en(int_en), .accept(accept_w), .pd(buf_gate),
        .first_edge(first_w), .pd_err(pd_err)
    );

    burst_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst(rst), .int_en(int_en), .accept(accept_w), .cmd(cmd),
        .bl_sel(bl_sel), .start_col(start_col), .flags(flags_w),
        .busy_nxt(busy_nxt_w), .col_q(col_w), .beat(beat_w),
        .beat_wr(beat_wr_w), .beat_col(cur_col)
    );

    beat_io #(.COL_W(COL_W), .DW(DW)) u_io (
        .clk(clk), .rst(rst), .beat(beat_w), .beat_wr(beat_wr_w),
        .beat_col(cur_col), .wdata(wdata), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_col(wr_col), .wr_data(wr_data), .dq_out(dq_out)
    );

    assign out_hold = flags_w.busy && !flags_w.is_wr && !int_en;
endmodule

// File: rtl/cke_ctrl_chk.sv
module cke_ctrl_chk #(
    parameter int COL_W = 9,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cke,
    input logic             int_en,
    input logic             buf_gate,
    input logic             busy,
    input logic [COL_W-1:0] col_q,
    input logic [DW-1:0]    dq_out,
    input logic             wr_stb,
    input logic             pd_err,
    input logic             first_edge
);
    p_en_low_r1: assert property (@(posedge clk) disable iff (rst) !cke |=> !int_en);
    p_en_high_r1: assert property (@(posedge clk) disable iff (rst) cke |=> int_en);
    p_no_write_r3: assert property (@(posedge clk) disable iff (rst) !int_en |=> !wr_stb);
    p_dq_hold_r4: assert property (@(posedge clk) disable iff (rst) !int_en |=> $stable(dq_out));
    p_col_hold_r5: assert property (@(posedge clk) disable iff (rst) !int_en |=> $stable(col_q));
    p_gate_idle_r7: assert property (@(posedge clk) disable iff (rst) buf_gate |-> !busy);
    p_gate_exit_r8: assert property (@(posedge clk) disable iff (rst) (buf_gate && cke) |=> !buf_gate);
    p_err_first_r11: assert property (@(posedge clk) disable iff (rst) $rose(pd_err) |-> $past(first_edge));
    p_reset_r12: assert property (@(posedge clk) rst |=> (int_en && !buf_gate && !pd_err && !busy));
endmodule

bind sdram_cke_ctrl cke_ctrl_chk #(.COL_W(COL_W), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .int_en(int_en), .buf_gate(buf_gate),
    .busy(flags_w.busy), .col_q(col_w), .dq_out(dq_out), .wr_stb(wr_stb),
    .pd_err(pd_err), .first_edge(first_w)
);

// File: tb/test_sdram_cke_ctrl.sv
module test_sdram_cke_ctrl;
    localparam int COL_W = 9;
    localparam int DW    = 16;

    typedef struct packed {
        logic             cke;
        logic [2:0]       cmd;
        logic [COL_W-1:0] col;
        logic [DW-1:0]    wd;
        logic             e_en;
        logic             e_wr;
        logic [COL_W-1:0] e_col;
        logic             e_gate;
    } vec_t;

    // BL4 (bl_sel=2); NOP=0 WRITE=3
    localparam vec_t VEC [17] = '{
        '{1'b1, 3'd0, 9'd0, 16'h0000, 1'b1, 1'b0, 9'd0, 1'b0},
        '{1'b1, 3'd3, 9'd5, 16'hA1A1, 1'b1, 1'b1, 9'd5, 1'b0},
        '{1'b0, 3'd0, 9'd0, 16'hA2A2, 1'b0, 1'b1, 9'd6, 1'b0},
        '{1'b0, 3'd3, 9'd0, 16'hA3A3, 1'b0, 1'b0, 9'd0, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hA4A4, 1'b1, 1'b0, 9'd0, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hA5A5, 1'b1, 1'b1, 9'd7, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hA6A6, 1'b1, 1'b1, 9'd4, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'h0000, 1'b1, 1'b0, 9'd0, 1'b0},
        '{1'b0, 3'd0, 9'd0, 16'h0000, 1'b0, 1'b0, 9'd0, 1'b1},
        '{1'b0, 3'd3, 9'd9, 16'hBEEF, 1'b0, 1'b0, 9'd0, 1'b1},
        '{1'b1, 3'd0, 9'd0, 16'h0000, 1'b1, 1'b0, 9'd0, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'h0000, 1'b1, 1'b0, 9'd0, 1'b0},
        '{1'b1, 3'd3, 9'd2, 16'hC0C0, 1'b1, 1'b1, 9'd2, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hC1C1, 1'b1, 1'b1, 9'd3, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hC2C2, 1'b1, 1'b1, 9'd0, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'hC3C3, 1'b1, 1'b1, 9'd1, 1'b0},
        '{1'b1, 3'd0, 9'd0, 16'h0000, 1'b1, 1'b0, 9'd0, 1'b0}
    };

    logic             clk = 1'b0, rst = 1'b1, cke = 1'b1;
    logic [2:0]       cmd = 3'd0;
    logic [1:0]       bl_sel = 2'd2;
    logic [COL_W-1:0] start_col = '0;
    logic [DW-1:0]    wdata = '0, rd_data;
    logic             int_en, wr_stb, out_hold, buf_gate, pd_err;
    logic [COL_W-1:0] cur_col, wr_col;
    logic [DW-1:0]    wr_data, dq_out;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign rd_data = 16'hD000 | 16'(cur_col);

    sdram_cke_ctrl #(.COL_W(COL_W), .DW(DW)) i_sdram_cke_ctrl (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bl_sel(bl_sel),
        .start_col(start_col), .wdata(wdata), .rd_data(rd_data),
        .int_en(int_en), .cur_col(cur_col), .wr_stb(wr_stb), .wr_col(wr_col),
        .wr_data(wr_data), .dq_out(dq_out), .out_hold(out_hold),
        .buf_gate(buf_gate), .pd_err(pd_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic k, input logic [2:0] c, input logic [COL_W-1:0] sc,
                         input logic [DW-1:0] wd);
        cke = k; cmd = c; start_col = sc; wdata = wd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 int_en", 32'(int_en), 32'd1);
        check("R12 buf_gate", 32'(buf_gate), 32'd0);
        check("R12 wr_stb", 32'(wr_stb), 32'd0);
        check("R12 pd_err", 32'(pd_err), 32'd0);

        // vector walk: R1 R3 R5 R6 R7 R8 R9 R10
        foreach (VEC[i]) begin
            drive(VEC[i].cke, VEC[i].cmd, VEC[i].col, VEC[i].wd);
            tick();
            check($sformatf("R1 int_en v%0d", i), 32'(int_en), 32'(VEC[i].e_en));
            check($sformatf("R3/R10 wr_stb v%0d", i), 32'(wr_stb), 32'(VEC[i].e_wr));
            check($sformatf("R7/R8 buf_gate v%0d", i), 32'(buf_gate), 32'(VEC[i].e_gate));
            if (VEC[i].e_wr) begin
                check($sformatf("R5/R6/R9 wr_col v%0d", i), 32'(wr_col), 32'(VEC[i].e_col));
                check($sformatf("R10 wr_data v%0d", i), 32'(wr_data), 32'(VEC[i].wd));
            end
        end

        // R9 burst length sweep, start column 3
        for (int sel = 0; sel < 4; sel++) begin
            automatic int n = 1 << sel;
            automatic int m = n - 1;
            bl_sel = 2'(sel);
            for (int b = 0; b <= n; b++) begin
                if (b == 0) drive(1'b1, 3'd3, 9'd3, 16'(16'h5000 + sel));
                else        drive(1'b1, 3'd0, 9'd0, 16'(16'h6000 + b));
                tick();
                if (b < n) begin
                    check($sformatf("R9 bl%0d beat%0d strobe", n, b), 32'(wr_stb), 32'd1);
                    check($sformatf("R9 bl%0d beat%0d col", n, b), 32'(wr_col),
                          32'((3 & ~m) | ((3 + b) & m)));
                end else begin
                    check($sformatf("R9 bl%0d end", n), 32'(wr_stb), 32'd0);
                end
            end
        end

        // R2 R3 R4 R5 R6: read burst, BL8 from column 0, frozen mid-burst
        bl_sel = 2'd3;
        drive(1'b1, 3'd2, 9'd0, 16'h0);
        tick();
        check("R6 first read word", 32'(dq_out), 32'hD000);
        check("R2 no hold when enabled", 32'(out_hold), 32'd0);
        drive(1'b0, 3'd0, 9'd0, 16'h0);
        tick();
        check("R1 beat at low sample edge", 32'(dq_out), 32'hD001);
        check("R2 hold raised", 32'(out_hold), 32'd1);
        drive(1'b0, 3'd2, 9'd5, 16'h1234);
        tick();
        check("R4 dq held", 32'(dq_out), 32'hD001);
        check("R3/R5 cur_col held against READ", 32'(cur_col), 32'd2);
        check("R2 hold kept", 32'(out_hold), 32'd1);
        drive(1'b1, 3'd0, 9'd0, 16'h0);
        tick();
        check("R4 dq held on release edge", 32'(dq_out), 32'hD001);
        check("R2 hold dropped", 32'(out_hold), 32'd0);
        check("R6 resume column", 32'(cur_col), 32'd2);
        tick();
        check("R6 resumed read word", 32'(dq_out), 32'hD002);
        repeat (6) tick();
        check("R9 read drained", 32'(dq_out), 32'hD007);

        // R11: illegal command right after power-down exit
        drive(1'b0, 3'd0, 9'd0, 16'h0);
        tick();
        check("R7 enter power-down", 32'(buf_gate), 32'd1);
        drive(1'b1, 3'd0, 9'd0, 16'h0);
        tick();
        check("R8 gate released", 32'(buf_gate), 32'd0);
        check("R8 int_en back", 32'(int_en), 32'd1);
        drive(1'b1, 3'd3, 9'd1, 16'h7777);
        tick();
        check("R11 pd_err set", 32'(pd_err), 32'd1);
        check("R11 command dropped", 32'(wr_stb), 32'd0);
        drive(1'b1, 3'd0, 9'd0, 16'h0);
        tick();
        check("R11 no burst started", 32'(wr_stb), 32'd0);
        check("R11 pd_err sticky", 32'(pd_err), 32'd1);

        // R12: reset with cke low
        rst = 1'b1;
        drive(1'b0, 3'd0, 9'd0, 16'h0);
        tick();
        check("R12 int_en forced", 32'(int_en), 32'd1);
        check("R12 pd_err cleared", 32'(pd_err), 32'd0);
        check("R12 gate cleared", 32'(buf_gate), 32'd0);
        rst = 1'b0;
        cke = 1'b1;
        tick();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule